// File: doc/BRIEF.md
# Protection-Unit Configuration Register File

This block holds the configuration state of a system-control coprocessor for a core that has a memory protection unit rather than a full page-table MMU. Software reaches it through a simple access port. Each access carries a primary register number, two sub-selectors (op2 and CRm), a write/read strobe and a 32-bit data word. Reads return data one cycle after the strobe.

The stored state covers several groups. There are two cacheability words, one for data and one for instruction, and a write-buffer control word. There are data and instruction access-permission words and eight region base/size words. Two lockdown words complete the set. All of this state is exported continuously to the region checker that sits beside the block.

The permission words are stored in an extended form of four bits per region. They can also be reached through a compact form of two bits per region, and the block converts between the two forms in both directions. Any selector combination the block does not define raises a one-cycle undefined-instruction flag and changes nothing.

Top module: `mpu_cfg_regfile`

## Requirements
- R1: After reset every stored word is zero, so every exported word reads zero and `undef_flag` and `rd_data` are zero.
- R2: Register 2 with op2=0 is the data cacheability word and with op2=1 the instruction cacheability word, each read/write over all 32 bits. Register 2 with any other op2 is undefined.
- R3: Register 3, with any op2 and CRm, is the single 32-bit write-buffer control word.
- R4: A write to register 5 with op2=0 (data) or op2=1 (instruction) uses the compact form. Field i, at write bits [2i+1:2i], goes to extended bits [4i+1:4i], and extended bits [4i+3:4i+2] are cleared. Write bits [31:16] have no effect.
- R5: A read of register 5 with op2=0 or op2=1 returns the extended bits [4i+1:4i] of the matching word at bits [2i+1:2i]. Read bits [31:16] are zero.
- R6: Register 5 with op2=2 (data) or op2=3 (instruction) reads and writes the full 32-bit extended permission word unchanged.
- R7: Register 6 with CRm=n for n<8 selects region word n for read and write. CRm of 8 or above is undefined.
- R8: Register 9 with CRm=0 selects the data lockdown word when op2=0 and the instruction lockdown word when op2=1. CRm=1 (tightly-coupled memory region), any other CRm and any other op2 are undefined.
- R9: A read of register 0 returns 0x41059461 when op2=0 and 0x0f004006 when op2=1. Writes to register 0 are undefined, and so is a read with any other op2.
- R10: Register numbers 1, 4, 7, 8 and 10 to 15 are undefined. An undefined access sets `undef_flag` for exactly the one cycle after the strobe, leaves all stored state unchanged, and returns zero on a read.
- R11: Read data appears on `rd_data` in the cycle after the strobe. In every cycle that does not follow a defined read, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_crn | input | 4 | Primary register number |
| acc_op2 | input | 3 | op2 sub-selector |
| acc_crm | input | 4 | CRm sub-selector |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| undef_flag | output | 1 | One-cycle undefined-access pulse |
| cache_data | output | 32 | Data cacheability word |
| cache_insn | output | 32 | Instruction cacheability word |
| wbuf_ctrl | output | 32 | Write-buffer control word |
| ap_data | output | 32 | Extended data permission word |
| ap_insn | output | 32 | Extended instruction permission word |
| region_flat | output | 256 | Region words; word n is bits [32n+31:32n] |

## Verification
The bench builds the block with its default parameters: eight regions, the 32-bit word, and the default identification constants. With eight regions the first out-of-range CRm is 8, and the compact view fills exactly bits [15:0]. This lets the bench reach the region boundary at CRm 7 and CRm 8 and the full round trip between the compact and extended permission forms. The bench also confirms, through the exported words and read-back, that undefined accesses leave the state unchanged.

// File: rtl/mpu_cfg_pkg.sv
package mpu_cfg_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ID,
        SEL_CTYPE,
        SEL_CACHE_D,
        SEL_CACHE_I,
        SEL_WBUF,
        SEL_AP_D_CMP,
        SEL_AP_I_CMP,
        SEL_AP_D_EXT,
        SEL_AP_I_EXT,
        SEL_REGION,
        SEL_LOCK_D,
        SEL_LOCK_I
    } sel_e;

endpackage

// File: rtl/mpu_cfg_decode.sv
module mpu_cfg_decode
    import mpu_cfg_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic       en,
    input  logic       wr,
    input  logic [3:0] crn,
    input  logic [2:0] op2,
    input  logic [3:0] crm,
    output sel_e       sel,
    output logic       undef
);

    always_comb begin
        sel = SEL_NONE;
        case (crn)
            4'd0: begin
                if (!wr) begin
                    if (op2 == 3'd0)      sel = SEL_ID;
                    else if (op2 == 3'd1) sel = SEL_CTYPE;
                end
            end
            4'd2: begin
                if (op2 == 3'd0)      sel = SEL_CACHE_D;
                else if (op2 == 3'd1) sel = SEL_CACHE_I;
            end
            4'd3: sel = SEL_WBUF;
            4'd5: begin
                case (op2)
                    3'd0:    sel = SEL_AP_D_CMP;
                    3'd1:    sel = SEL_AP_I_CMP;
                    3'd2:    sel = SEL_AP_D_EXT;
                    3'd3:    sel = SEL_AP_I_EXT;
                    default: sel = SEL_NONE;
                endcase
            end
            4'd6: begin
                if (int'(crm) < NREG) sel = SEL_REGION;
            end
            4'd9: begin
                if (crm == 4'd0) begin
                    if (op2 == 3'd0)      sel = SEL_LOCK_D;
                    else if (op2 == 3'd1) sel = SEL_LOCK_I;
                end
            end
            default: sel = SEL_NONE;
        endcase
        undef = en && (sel == SEL_NONE);
    end

endmodule

// File: rtl/mpu_ap_convert.sv
module mpu_ap_convert #(
    parameter int NREG = 8,
    localparam int CW  = 2 * NREG,
    localparam int EW  = 4 * NREG
) (
    input  logic [EW-1:0] ext_d,
    input  logic [EW-1:0] ext_i,
    input  logic [CW-1:0] cmp_in,
    output logic [CW-1:0] pack_d,
    output logic [CW-1:0] pack_i,
    output logic [EW-1:0] expand
);

    for (genvar g = 0; g < NREG; g++) begin : g_field
        assign pack_d[2*g +: 2]   = ext_d[4*g +: 2];
        assign pack_i[2*g +: 2]   = ext_i[4*g +: 2];
        assign expand[4*g +: 4]   = {2'b00, cmp_in[2*g +: 2]};
    end

endmodule

// File: rtl/mpu_cfg_regfile.sv
module mpu_cfg_regfile
    import mpu_cfg_pkg::*;
#(
    parameter int          NREG      = 8,
    parameter int          DW        = 32,
    parameter logic [31:0] ID_VAL    = 32'h41059461,
    parameter logic [31:0] CTYPE_VAL = 32'h0f004006,
    localparam int         CW        = 2 * NREG,
    localparam int         EW        = 4 * NREG,
    localparam int         RIW       = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic               acc_wr,
    input  logic [3:0]         acc_crn,
    input  logic [2:0]         acc_op2,
    input  logic [3:0]         acc_crm,
    input  logic [DW-1:0]      acc_wdata,
    output logic [DW-1:0]      rd_data,
    output logic               undef_flag,
    output logic [DW-1:0]      cache_data,
    output logic [DW-1:0]      cache_insn,
    output logic [DW-1:0]      wbuf_ctrl,
    output logic [EW-1:0]      ap_data,
    output logic [EW-1:0]      ap_insn,
    output logic [NREG*DW-1:0] region_flat
);

    typedef struct packed {
        logic [DW-1:0]            cache_d;
        logic [DW-1:0]            cache_i;
        logic [DW-1:0]            wbuf;
        logic [EW-1:0]            ap_d;
        logic [EW-1:0]            ap_i;
        logic [DW-1:0]            lock_d;
        logic [DW-1:0]            lock_i;
        logic [NREG-1:0][DW-1:0]  region;
        logic [DW-1:0]            rd;
        logic                     undef;
    } state_t;

    state_t st_d, st_q;

    sel_e          sel;
    logic          dec_undef;
    logic [CW-1:0] pack_d, pack_i;
    logic [EW-1:0] expand;
    logic [RIW-1:0] ridx;

    assign ridx = acc_crm[RIW-1:0];

    mpu_cfg_decode #(.NREG(NREG)) u_dec (
        .en    (acc_en),
        .wr    (acc_wr),
        .crn   (acc_crn),
        .op2   (acc_op2),
        .crm   (acc_crm),
        .sel   (sel),
        .undef (dec_undef)
    );

    mpu_ap_convert #(.NREG(NREG)) u_conv (
        .ext_d  (st_q.ap_d),
        .ext_i  (st_q.ap_i),
        .cmp_in (acc_wdata[CW-1:0]),
        .pack_d (pack_d),
        .pack_i (pack_i),
        .expand (expand)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rd    = '0;
        st_d.undef = dec_undef;
        if (acc_en && !dec_undef) begin
            if (acc_wr) begin
                case (sel)
                    SEL_CACHE_D:  st_d.cache_d      = acc_wdata;
                    SEL_CACHE_I:  st_d.cache_i      = acc_wdata;
                    SEL_WBUF:     st_d.wbuf         = acc_wdata;
                    SEL_AP_D_CMP: st_d.ap_d         = expand;
                    SEL_AP_I_CMP: st_d.ap_i         = expand;
                    SEL_AP_D_EXT: st_d.ap_d         = acc_wdata[EW-1:0];
                    SEL_AP_I_EXT: st_d.ap_i         = acc_wdata[EW-1:0];
                    SEL_REGION:   st_d.region[ridx] = acc_wdata;
                    SEL_LOCK_D:   st_d.lock_d       = acc_wdata;
                    SEL_LOCK_I:   st_d.lock_i       = acc_wdata;
                    default:      ;
                endcase
            end else begin
                case (sel)
                    SEL_ID:       st_d.rd = DW'(ID_VAL);
                    SEL_CTYPE:    st_d.rd = DW'(CTYPE_VAL);
                    SEL_CACHE_D:  st_d.rd = st_q.cache_d;
                    SEL_CACHE_I:  st_d.rd = st_q.cache_i;
                    SEL_WBUF:     st_d.rd = st_q.wbuf;
                    SEL_AP_D_CMP: st_d.rd = DW'(pack_d);
                    SEL_AP_I_CMP: st_d.rd = DW'(pack_i);
                    SEL_AP_D_EXT: st_d.rd = DW'(st_q.ap_d);
                    SEL_AP_I_EXT: st_d.rd = DW'(st_q.ap_i);
                    SEL_REGION:   st_d.rd = st_q.region[ridx];
                    SEL_LOCK_D:   st_d.rd = st_q.lock_d;
                    SEL_LOCK_I:   st_d.rd = st_q.lock_i;
                    default:      st_d.rd = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data     = st_q.rd;
    assign undef_flag  = st_q.undef;
    assign cache_data  = st_q.cache_d;
    assign cache_insn  = st_q.cache_i;
    assign wbuf_ctrl   = st_q.wbuf;
    assign ap_data     = st_q.ap_d;
    assign ap_insn     = st_q.ap_i;
    assign region_flat = st_q.region;

endmodule

module mpu_cfg_regfile_chk #(
    parameter int          NREG      = 8,
    parameter int          DW        = 32,
    parameter logic [31:0] ID_VAL    = 32'h41059461,
    localparam int         EW        = 4 * NREG
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_en,
    input logic               acc_wr,
    input logic [3:0]         acc_crn,
    input logic [2:0]         acc_op2,
    input logic [3:0]         acc_crm,
    input logic [DW-1:0]      rd_data,
    input logic               undef_flag,
    input logic [DW-1:0]      cache_data,
    input logic [DW-1:0]      cache_insn,
    input logic [DW-1:0]      wbuf_ctrl,
    input logic [EW-1:0]      ap_data,
    input logic [EW-1:0]      ap_insn,
    input logic [NREG*DW-1:0] region_flat
);

    logic [EW-1:0] hi_mask;
    always_comb begin
        hi_mask = '0;
        for (int i = 0; i < NREG; i++) hi_mask[4*i+2 +: 2] = 2'b11;
    end

    // R10: no flag without a strobe in the previous cycle
    a_r10_flag_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_en) |-> !undef_flag);

    // R10: undefined access changes no state
    a_r10_undef_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |-> ($stable(cache_data) && $stable(cache_insn) && $stable(wbuf_ctrl)
                        && $stable(ap_data) && $stable(ap_insn) && $stable(region_flat)));

    // R10: undefined access returns zero
    a_r10_undef_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |-> (rd_data == '0));

    // R7: out-of-range region selector is flagged
    a_r7_region_range: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_crn == 4'd6 && int'(acc_crm) >= NREG) |=> undef_flag);

    // R4: compact data write leaves upper nibble bits clear
    a_r4_compact_clears_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_crn == 4'd5 && acc_op2 == 3'd0) |=> ((ap_data & hi_mask) == '0));

    // R9: identification read
    a_r9_id_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_crn == 4'd0 && acc_op2 == 3'd0) |=> (rd_data == DW'(ID_VAL)));

    // R11: no read data without a preceding read
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_en && !acc_wr) |-> (rd_data == '0));

endmodule

bind mpu_cfg_regfile mpu_cfg_regfile_chk #(.NREG(NREG), .DW(DW), .ID_VAL(ID_VAL)) u_chk (.*);

// File: tb/mpu_cfg_regfile_test.sv
module mpu_cfg_regfile_test;

    localparam int NREG = 8;
    localparam int DW   = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_en = 1'b0, acc_wr = 1'b0;
    logic [3:0] acc_crn = '0;
    logic [2:0] acc_op2 = '0;
    logic [3:0] acc_crm = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic undef_flag;
    logic [31:0] cache_data, cache_insn, wbuf_ctrl, ap_data, ap_insn;
    logic [NREG*DW-1:0] region_flat;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mpu_cfg_regfile uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_crn(acc_crn), .acc_op2(acc_op2), .acc_crm(acc_crm), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .undef_flag(undef_flag), .cache_data(cache_data),
        .cache_insn(cache_insn), .wbuf_ctrl(wbuf_ctrl), .ap_data(ap_data),
        .ap_insn(ap_insn), .region_flat(region_flat)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one access: driven at negedge, registered at posedge, sampled 1 ns later
    task automatic acc(input logic wr, input logic [3:0] crn, input logic [2:0] op2,
                       input logic [3:0] crm, input logic [31:0] wd,
                       output logic [31:0] rd, output logic und);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_crn = crn; acc_op2 = op2; acc_crm = crm; acc_wdata = wd;
        @(posedge clk);
        #1;
        rd = rd_data; und = undef_flag;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
    endtask

    function automatic logic [31:0] to_ext(logic [31:0] c);
        logic [31:0] e = '0;
        for (int i = 0; i < NREG; i++) e[4*i +: 2] = c[2*i +: 2];
        return e;
    endfunction

    function automatic logic [31:0] to_cmp(logic [31:0] e);
        logic [31:0] c = '0;
        for (int i = 0; i < NREG; i++) c[2*i +: 2] = e[4*i +: 2];
        return c;
    endfunction

    task automatic t_reset();
        check("R1 cache_data", cache_data, 0);
        check("R1 ap_insn", ap_insn, 0);
        check("R1 region_flat", region_flat[31:0] | region_flat[255:224], 0);
        check("R1 undef_flag", {31'b0, undef_flag}, 0);
        check("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_cache();
        logic [31:0] r; logic u;
        acc(1, 4'd2, 3'd0, 4'd0, 32'hA5A5_0F0F, r, u);
        acc(1, 4'd2, 3'd1, 4'd0, 32'h1234_5678, r, u);
        check("R2 cache_data port", cache_data, 32'hA5A5_0F0F);
        acc(0, 4'd2, 3'd0, 4'd0, 0, r, u);
        check("R2 data read", r, 32'hA5A5_0F0F);
        acc(0, 4'd2, 3'd1, 4'd0, 0, r, u);
        check("R2 insn read", r, 32'h1234_5678);
        acc(1, 4'd2, 3'd2, 4'd0, 32'hFFFF_FFFF, r, u);
        check("R2 op2=2 undef", {31'b0, u}, 1);
        check("R2 op2=2 no change", cache_data ^ cache_insn, 32'hA5A5_0F0F ^ 32'h1234_5678);
    endtask

    task automatic t_wbuf();
        logic [31:0] r; logic u;
        acc(1, 4'd3, 3'd5, 4'd3, 32'h0000_00C3, r, u);
        check("R3 wbuf port", wbuf_ctrl, 32'h0000_00C3);
        acc(0, 4'd3, 3'd0, 4'd0, 0, r, u);
        check("R3 wbuf read", r, 32'h0000_00C3);
    endtask

    task automatic t_perm();
        logic [31:0] r; logic u;
        acc(1, 4'd5, 3'd2, 4'd0, 32'hFFFF_FFFF, r, u);
        check("R6 ext data port", ap_data, 32'hFFFF_FFFF);
        acc(0, 4'd5, 3'd0, 4'd0, 0, r, u);
        check("R5 compact data read", r, 32'h0000_FFFF);
        acc(1, 4'd5, 3'd0, 4'd0, 32'hFFFF_5A5A, r, u);
        check("R4 compact data write", ap_data, to_ext(32'h5A5A));
        check("R4 literal", ap_data, 32'h1122_1122);
        acc(0, 4'd5, 3'd2, 4'd0, 0, r, u);
        check("R6 ext data read", r, 32'h1122_1122);
        acc(1, 4'd5, 3'd3, 4'd0, 32'h6543_2DCB, r, u);
        acc(0, 4'd5, 3'd3, 4'd0, 0, r, u);
        check("R6 ext insn read", r, 32'h6543_2DCB);
        acc(0, 4'd5, 3'd1, 4'd0, 0, r, u);
        check("R5 compact insn read", r, to_cmp(32'h6543_2DCB));
        acc(1, 4'd5, 3'd1, 4'd0, 32'h0000_9C36, r, u);
        check("R4 compact insn write", ap_insn, to_ext(32'h9C36));
        check("R4 data untouched", ap_data, 32'h1122_1122);
        acc(1, 4'd5, 3'd4, 4'd0, 32'hDEAD_BEEF, r, u);
        check("R10 op2=4 undef", {31'b0, u}, 1);
    endtask

    task automatic t_region();
        logic [31:0] r; logic u;
        for (int n = 0; n < NREG; n++)
            acc(1, 4'd6, 3'd0, 4'(n), 32'h1000_0001 + 32'(n) * 32'h0101_0100, r, u);
        for (int n = 0; n < NREG; n++) begin
            acc(0, 4'd6, 3'd0, 4'(n), 0, r, u);
            check("R7 region read", r, 32'h1000_0001 + 32'(n) * 32'h0101_0100);
        end
        check("R7 region7 port", region_flat[255:224], 32'h1000_0001 + 32'd7 * 32'h0101_0100);
        acc(1, 4'd6, 3'd0, 4'd8, 32'hFFFF_FFFF, r, u);
        check("R7 crm8 undef", {31'b0, u}, 1);
        check("R7 crm8 region0 kept", region_flat[31:0], 32'h1000_0001);
        acc(0, 4'd6, 3'd0, 4'd15, 0, r, u);
        check("R7 crm15 read undef", {31'b0, u}, 1);
        check("R10 undef read zero", r, 0);
    endtask

    task automatic t_lock();
        logic [31:0] r; logic u;
        acc(1, 4'd9, 3'd0, 4'd0, 32'h0000_0003, r, u);
        acc(1, 4'd9, 3'd1, 4'd0, 32'h8000_0001, r, u);
        acc(0, 4'd9, 3'd0, 4'd0, 0, r, u);
        check("R8 lock data", r, 32'h0000_0003);
        acc(0, 4'd9, 3'd1, 4'd0, 0, r, u);
        check("R8 lock insn", r, 32'h8000_0001);
        acc(1, 4'd9, 3'd0, 4'd1, 32'hFFFF_FFFF, r, u);
        check("R8 crm1 undef", {31'b0, u}, 1);
        acc(0, 4'd9, 3'd0, 4'd0, 0, r, u);
        check("R8 crm1 no change", r, 32'h0000_0003);
        acc(0, 4'd9, 3'd2, 4'd0, 0, r, u);
        check("R8 op2=2 undef", {31'b0, u}, 1);
    endtask

    task automatic t_id();
        logic [31:0] r; logic u;
        acc(0, 4'd0, 3'd0, 4'd0, 0, r, u);
        check("R9 main id", r, 32'h4105_9461);
        acc(0, 4'd0, 3'd1, 4'd0, 0, r, u);
        check("R9 cache type", r, 32'h0f00_4006);
        acc(1, 4'd0, 3'd0, 4'd0, 32'h1, r, u);
        check("R9 write undef", {31'b0, u}, 1);
        acc(0, 4'd0, 3'd2, 4'd0, 0, r, u);
        check("R9 op2=2 undef", {31'b0, u}, 1);
    endtask

    task automatic t_undef_misc();
        logic [31:0] r; logic u;
        acc(1, 4'd7, 3'd0, 4'd0, 32'hFFFF_FFFF, r, u);
        check("R10 crn7 undef", {31'b0, u}, 1);
        #9;
        check("R10 flag one cycle", {31'b0, undef_flag}, 0);
        acc(0, 4'd1, 3'd0, 4'd0, 0, r, u);
        check("R10 crn1 undef", {31'b0, u}, 1);
        acc(0, 4'd2, 3'd0, 4'd0, 0, r, u);
        check("R10 state kept", r, 32'hA5A5_0F0F);
        check("R2 defined read no flag", {31'b0, u}, 0);
        #9;
        check("R11 rd_data idle zero", rd_data, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                #1;
                t_reset();
                t_cache();
                t_wbuf();
                t_perm();
                t_region();
                t_lock();
                t_id();
                t_undef_misc();
            end
            begin
                repeat (20000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule